// File: doc/BRIEF.md
# Periodic Motor Drive Update Scheduler

This block turns two drive-level bytes, one per motor, into a latched magnitude and a direction bit for a local module with motors A and B. The latched values change only at update events. An update event is either the expiry of a programmable period, counted in millisecond ticks, or a one-cycle force strobe. Between events the motor outputs stay frozen, even when the drive bytes change.

Each motor has an invert bit that reverses its direction. When the bridge bit is set, both motors are driven from motor A's byte and motor A's invert bit. A global enable byte gates the outputs. A failsafe event pulse always increments a saturating fault counter. Depending on bit 0 of the failsafe control byte, the event either leaves the last drive untouched or clears it to stop.

Top module: `mdrv_sched`

## Requirements
- R1: While reset is asserted and directly after it, both magnitudes are 0, both direction bits are 0, `drv_en_o` is 0 and the fault counter is 0.
- R2: A drive byte is offset binary around 0x80. A byte b above 0x80 latches direction 1 (forward) and magnitude b-0x80. A byte below 0x80 latches direction 0 and magnitude 0x80-b. Exactly 0x80 latches magnitude 0 and direction 0.
- R3: A set invert bit flips the latched direction of its motor whenever the magnitude is nonzero. A stopped motor always shows direction 0.
- R4: With `bridge_i` at 1, an update latches the same magnitude and direction on both motors, computed from `drive_a_i` and `inv_a_i`. `drive_b_i` and `inv_b_i` have no effect in this mode.
- R5: With a nonzero rate R, an update happens on the clock edge that samples the R-th `tick_ms_i` pulse after the last restart of the period. Drive changes before that edge do not reach the outputs.
- R6: With a rate of 0, ticks never cause an update, so the outputs change only on a force strobe.
- R7: `force_i` high for one cycle updates both motors on that clock edge. It also restarts the period count, so the next periodic update needs R further ticks.
- R8: `rate_wr_i` high for one cycle restarts the period count, so the next periodic update needs R further ticks.
- R9: `drv_en_o` is 1 one cycle after `enable_i` equals 0x01, and 0 for any other value. While it is 0 both magnitudes read 0. The latched drive is kept and reappears when the driver is enabled again.
- R10: A `fs_event_i` pulse with `fs_ctrl_i[0]` at 1 clears both latched magnitudes and directions on that edge, and this wins over a simultaneous update. With bit 0 at 0 the event leaves the latched drive unchanged.
- R11: Each `fs_event_i` pulse increments `fault_cnt_o` by one. The counter saturates at its maximum (255 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms_i | input | 1 | One-cycle pulse every millisecond |
| drive_a_i | input | 8 | Drive level of motor A, offset binary |
| drive_b_i | input | 8 | Drive level of motor B, offset binary |
| inv_a_i | input | 1 | Reverse direction of motor A (both motors when bridged) |
| inv_b_i | input | 1 | Reverse direction of motor B |
| bridge_i | input | 1 | Drive both motors from motor A settings |
| enable_i | input | 8 | Driver enable byte, 0x01 enables |
| rate_i | input | 8 | Update period in ticks, 0 means force only |
| rate_wr_i | input | 1 | Pulse marking a write of the rate, restarts the period |
| force_i | input | 1 | One-cycle force update strobe |
| fs_event_i | input | 1 | One-cycle failsafe event |
| fs_ctrl_i | input | 8 | Failsafe control, bit 0 selects clear-to-stop |
| mag_a_o | output | 8 | Latched magnitude of motor A, gated by enable |
| dir_a_o | output | 1 | Latched direction of motor A, 1 forward |
| mag_b_o | output | 8 | Latched magnitude of motor B, gated by enable |
| dir_b_o | output | 1 | Latched direction of motor B, 1 forward |
| drv_en_o | output | 1 | Driver enable output |
| fault_cnt_o | output | 8 | Saturating count of failsafe events |

## Verification
If the period counter is corrupted, the update edge moves, and the outputs switch to the new drive one or more ticks early or late. That shows at the very first tick-counted update after a rate write or a force. If the latch has the wrong priority or a wrong hold path, the outputs change without an event, or a failsafe clear is lost in the same cycle as a force. Either fault is visible one edge after the stimulus. A wrong decode is visible immediately after any update: in the sign or size of the magnitude, in how the invert bit is applied, or in which byte feeds the bridged motors.

// File: rtl/mdrv_pkg.sv
package mdrv_pkg;

  // Value of the enable byte that turns the drivers on
  localparam int unsigned ENABLE_CODE = 1;

  // Failsafe policy selected by control bit 0
  typedef enum logic {
    FS_HOLD = 1'b0,
    FS_ZERO = 1'b1
  } fs_policy_e;

  // Action of the drive latch in one cycle
  typedef enum logic [1:0] {
    LAT_KEEP  = 2'd0,
    LAT_LOAD  = 2'd1,
    LAT_CLEAR = 2'd2
  } lat_op_e;

endpackage

// File: rtl/mdrv_shape.sv
module mdrv_shape #(
  parameter int unsigned DRV_W = 8
) (
  input  logic [DRV_W-1:0] level_i,
  input  logic             invert_i,
  output logic [DRV_W-1:0] mag_o,
  output logic             fwd_o
);

  localparam logic [DRV_W-1:0] MID = {1'b1, {(DRV_W-1){1'b0}}};

  logic fwd_raw;

  always_comb begin
    if (level_i > MID) begin
      mag_o   = level_i - MID;
      fwd_raw = 1'b1;
    end else if (level_i < MID) begin
      mag_o   = MID - level_i;
      fwd_raw = 1'b0;
    end else begin
      mag_o   = '0;
      fwd_raw = 1'b0;
    end
    // a stopped motor has no direction
    fwd_o = (mag_o != '0) & (fwd_raw ^ invert_i);
  end

endmodule

// File: rtl/mdrv_period.sv
module mdrv_period #(
  parameter int unsigned RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              rate_wr_i,
  input  logic              tick_i,
  input  logic              force_i,
  output logic              upd_o
);

  logic [RATE_W-1:0] cnt_q;
  logic [RATE_W-1:0] cnt_d;
  logic              cnt_en;
  logic              rate_on;
  logic              hit;

  assign rate_on = (rate_i != '0);
  assign hit     = tick_i & rate_on & (cnt_q >= (rate_i - RATE_W'(1)));
  assign upd_o   = force_i | hit;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (rate_wr_i || upd_o) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (tick_i && rate_on) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + RATE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_RATE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rate_wr_i |=> (cnt_q == '0)); // R8

  AST_PERIOD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && rate_on && !upd_o && !rate_wr_i) |=> (cnt_q == $past(cnt_q) + RATE_W'(1))); // R5

  AST_IDLE_RATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!rate_on && !force_i && !rate_wr_i) |=> $stable(cnt_q)); // R6

endmodule

// File: rtl/mdrv_hold.sv
module mdrv_hold
  import mdrv_pkg::*;
#(
  parameter int unsigned DRV_W = 8,
  parameter int unsigned FC_W  = 8,
  parameter int unsigned NMOT  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       upd_i,
  input  logic [NMOT-1:0][DRV_W-1:0] mag_i,
  input  logic [NMOT-1:0]            fwd_i,
  input  logic                       fs_evt_i,
  input  logic                       fs_zero_i,
  output logic [NMOT-1:0][DRV_W-1:0] mag_q,
  output logic [NMOT-1:0]            fwd_q,
  output logic [FC_W-1:0]            fault_q
);

  localparam logic [FC_W-1:0] FC_MAX = {FC_W{1'b1}};

  lat_op_e                    op;
  logic [NMOT-1:0][DRV_W-1:0] mag_d;
  logic [NMOT-1:0]            fwd_d;
  logic                       lat_en;
  logic [FC_W-1:0]            fault_d;
  logic                       fault_en;

  always_comb begin
    if (fs_evt_i && fs_zero_i) begin
      op = LAT_CLEAR;
    end else if (upd_i) begin
      op = LAT_LOAD;
    end else begin
      op = LAT_KEEP;
    end
  end

  always_comb begin
    lat_en = (op != LAT_KEEP);
    mag_d  = mag_q;
    fwd_d  = fwd_q;
    case (op)
      LAT_LOAD: begin
        mag_d = mag_i;
        fwd_d = fwd_i;
      end
      LAT_CLEAR: begin
        mag_d = '0;
        fwd_d = '0;
      end
      default: ;
    endcase
  end

  always_comb begin
    fault_en = fs_evt_i && (fault_q != FC_MAX);
    fault_d  = fault_q + FC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q <= '0;
      fwd_q <= '0;
    end else if (lat_en) begin
      mag_q <= mag_d;
      fwd_q <= fwd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= '0;
    end else if (fault_en) begin
      fault_q <= fault_d;
    end
  end

  AST_FS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_evt_i && fs_zero_i) |=> (mag_q == '0 && fwd_q == '0)); // R10

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_i && !(fs_evt_i && fs_zero_i)) |=> ($stable(mag_q) && $stable(fwd_q))); // R5

  AST_FAULT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_evt_i && fault_q != FC_MAX) |=> (fault_q == $past(fault_q) + FC_W'(1))); // R11

  AST_FAULT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q == FC_MAX) |=> (fault_q == FC_MAX)); // R11

endmodule

// File: rtl/mdrv_sched.sv
module mdrv_sched
  import mdrv_pkg::*;
#(
  parameter int unsigned DRV_W  = 8,
  parameter int unsigned RATE_W = 8,
  parameter int unsigned EN_W   = 8,
  parameter int unsigned FSC_W  = 8,
  parameter int unsigned FC_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ms_i,
  input  logic [DRV_W-1:0]  drive_a_i,
  input  logic [DRV_W-1:0]  drive_b_i,
  input  logic              inv_a_i,
  input  logic              inv_b_i,
  input  logic              bridge_i,
  input  logic [EN_W-1:0]   enable_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              rate_wr_i,
  input  logic              force_i,
  input  logic              fs_event_i,
  input  logic [FSC_W-1:0]  fs_ctrl_i,
  output logic [DRV_W-1:0]  mag_a_o,
  output logic              dir_a_o,
  output logic [DRV_W-1:0]  mag_b_o,
  output logic              dir_b_o,
  output logic              drv_en_o,
  output logic [FC_W-1:0]   fault_cnt_o
);

  localparam int unsigned NMOT = 2;

  logic [NMOT-1:0][DRV_W-1:0] lvl_sel;
  logic [NMOT-1:0]            inv_sel;
  logic [NMOT-1:0][DRV_W-1:0] mag_new;
  logic [NMOT-1:0]            fwd_new;
  logic [NMOT-1:0][DRV_W-1:0] mag_q;
  logic [NMOT-1:0]            fwd_q;
  logic                       upd;
  logic                       fs_zero;
  logic                       en_q;
  logic                       en_d;

  // source selection: bridged mode feeds both motors from motor A
  always_comb begin
    lvl_sel[0] = drive_a_i;
    inv_sel[0] = inv_a_i;
    lvl_sel[1] = bridge_i ? drive_a_i : drive_b_i;
    inv_sel[1] = bridge_i ? inv_a_i   : inv_b_i;
  end

  for (genvar m = 0; m < NMOT; m++) begin : g_mot
    mdrv_shape #(
      .DRV_W (DRV_W)
    ) u_shape (
      .level_i  (lvl_sel[m]),
      .invert_i (inv_sel[m]),
      .mag_o    (mag_new[m]),
      .fwd_o    (fwd_new[m])
    );
  end

  mdrv_period #(
    .RATE_W (RATE_W)
  ) u_period (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_i    (rate_i),
    .rate_wr_i (rate_wr_i),
    .tick_i    (tick_ms_i),
    .force_i   (force_i),
    .upd_o     (upd)
  );

  assign fs_zero = (fs_policy_e'(fs_ctrl_i[0]) == FS_ZERO);

  mdrv_hold #(
    .DRV_W (DRV_W),
    .FC_W  (FC_W),
    .NMOT  (NMOT)
  ) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_i     (upd),
    .mag_i     (mag_new),
    .fwd_i     (fwd_new),
    .fs_evt_i  (fs_event_i),
    .fs_zero_i (fs_zero),
    .mag_q     (mag_q),
    .fwd_q     (fwd_q),
    .fault_q   (fault_cnt_o)
  );

  assign en_d = (enable_i == EN_W'(ENABLE_CODE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_d;
    end
  end

  assign drv_en_o = en_q;
  assign mag_a_o  = en_q ? mag_q[0] : '0;
  assign mag_b_o  = en_q ? mag_q[1] : '0;
  assign dir_a_o  = fwd_q[0];
  assign dir_b_o  = fwd_q[1];

  AST_BRIDGE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bridge_i && upd && !(fs_event_i && fs_zero)) |=> (mag_q[0] == mag_q[1] && fwd_q[0] == fwd_q[1])); // R4

  AST_EN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drv_en_o == ($past(enable_i) == EN_W'(ENABLE_CODE)))); // R9

  AST_STOP_NO_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (mag_q[0] == '0) |-> !fwd_q[0]); // R3

endmodule

// File: tb/mdrv_sched_tb_top.sv
module mdrv_sched_tb_top;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic [7:0] drv_a, drv_b;
  logic       inv_a, inv_b, bridge;
  logic [7:0] enable, rate, fs_ctrl;
  logic       rate_wr, force_upd, fs_evt;
  logic [7:0] mag_a, mag_b, fault_cnt;
  logic       dir_a, dir_b, drv_en;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_fault = 0;
  bit done = 0;

  mdrv_sched dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_ms_i   (tick),
    .drive_a_i   (drv_a),
    .drive_b_i   (drv_b),
    .inv_a_i     (inv_a),
    .inv_b_i     (inv_b),
    .bridge_i    (bridge),
    .enable_i    (enable),
    .rate_i      (rate),
    .rate_wr_i   (rate_wr),
    .force_i     (force_upd),
    .fs_event_i  (fs_evt),
    .fs_ctrl_i   (fs_ctrl),
    .mag_a_o     (mag_a),
    .dir_a_o     (dir_a),
    .mag_b_o     (mag_b),
    .dir_b_o     (dir_b),
    .drv_en_o    (drv_en),
    .fault_cnt_o (fault_cnt)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_mag(input int b);
    return (b >= 128) ? b - 128 : 128 - b;
  endfunction

  function automatic int exp_dir(input int b, input int inv);
    if (b == 128) return 0;
    return ((b > 128) ? 1 : 0) ^ inv;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1'b1; step(); tick = 1'b0;
  endtask

  task automatic pulse_force();
    force_upd = 1'b1; step(); force_upd = 1'b0;
  endtask

  task automatic write_rate(input int r);
    rate = 8'(r); rate_wr = 1'b1; step(); rate_wr = 1'b0;
  endtask

  task automatic pulse_fs();
    fs_evt = 1'b1; step(); fs_evt = 1'b0;
    if (exp_fault < 255) exp_fault++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 0; drv_a = 8'h80; drv_b = 8'h80;
    inv_a = 0; inv_b = 0; bridge = 0; enable = 0; rate = 0;
    fs_ctrl = 0; rate_wr = 0; force_upd = 0; fs_evt = 0;
    repeat (4) step();
    chk("R1 mag_a in reset", mag_a, 0);
    rst_n = 1'b1;
    step();
    chk("R1 mag_a", mag_a, 0);
    chk("R1 mag_b", mag_b, 0);
    chk("R1 dir_a", dir_a, 0);
    chk("R1 drv_en", drv_en, 0);
    chk("R1 fault", fault_cnt, 0);

    enable = 8'h01; step();
    chk("R9 enable on", drv_en, 1);
    write_rate(0);

    // R2 / R3: every drive byte, motor B inverted
    inv_a = 0; inv_b = 1;
    for (int b = 0; b < 256; b++) begin
      drv_a = 8'(b); drv_b = 8'(b);
      pulse_force();
      chk("R2 mag_a", mag_a, exp_mag(b));
      chk("R2 dir_a", dir_a, exp_dir(b, 0));
      chk("R3 mag_b", mag_b, exp_mag(b));
      chk("R3 dir_b", dir_b, exp_dir(b, 1));
    end
    // R3: inversion on motor A
    inv_a = 1; inv_b = 0;
    for (int b = 0; b < 256; b += 5) begin
      drv_a = 8'(b);
      pulse_force();
      chk("R3 dir_a inverted", dir_a, exp_dir(b, 1));
    end

    // R6: rate 0, ticks do nothing
    inv_a = 0; drv_a = 8'hFF; pulse_force();
    drv_a = 8'h40;
    for (int i = 0; i < 12; i++) pulse_tick();
    chk("R6 no periodic update", mag_a, 127);
    chk("R6 dir held", dir_a, 1);

    // R4: bridge sweep, B settings must not matter
    bridge = 1;
    for (int b = 0; b < 256; b += 7) begin
      drv_a = 8'(b); drv_b = 8'(255 - b);
      inv_a = b[1]; inv_b = ~b[1];
      pulse_force();
      chk("R4 mag_b follows A", mag_b, exp_mag(b));
      chk("R4 dir_b follows A", dir_b, exp_dir(b, int'(b[1])));
      chk("R4 dir_a", dir_a, exp_dir(b, int'(b[1])));
    end
    bridge = 0; inv_a = 0; inv_b = 0;

    // R5: period sweep
    drv_a = 8'h80; pulse_force();
    for (int r = 1; r <= 6; r++) begin
      write_rate(r);
      drv_a = 8'(8'h80 + 8'(r * 3));
      for (int t = 0; t < r - 1; t++) pulse_tick();
      chk("R5 before period", mag_a, (r == 1) ? 0 : (r - 1) * 3);
      pulse_tick();
      chk("R5 at period", mag_a, r * 3);
      chk("R5 dir", dir_a, 1);
    end
    // second period at rate 6 without reload
    drv_a = 8'h70;
    for (int t = 0; t < 5; t++) pulse_tick();
    chk("R5 second period early", mag_a, 18);
    pulse_tick();
    chk("R5 second period", mag_a, 16);
    chk("R5 second dir", dir_a, 0);

    // R7: force restarts the period
    write_rate(4);
    pulse_tick(); pulse_tick();
    drv_a = 8'h85; pulse_force();
    chk("R7 force update", mag_a, 5);
    drv_a = 8'h88;
    pulse_tick(); pulse_tick(); pulse_tick();
    chk("R7 period restarted", mag_a, 5);
    pulse_tick();
    chk("R7 update after restart", mag_a, 8);

    // R8: rate write restarts the period
    write_rate(4);
    pulse_tick(); pulse_tick(); pulse_tick();
    write_rate(4);
    drv_a = 8'h8C;
    pulse_tick(); pulse_tick(); pulse_tick();
    chk("R8 period restarted", mag_a, 8);
    pulse_tick();
    chk("R8 update after restart", mag_a, 12);

    // R9: enable gating
    enable = 8'h00; step();
    chk("R9 disabled", drv_en, 0);
    chk("R9 mag gated", mag_a, 0);
    enable = 8'h02; step();
    chk("R9 other code", drv_en, 0);
    enable = 8'h01; step();
    chk("R9 re-enabled", drv_en, 1);
    chk("R9 value kept", mag_a, 12);

    // R10 / R11: failsafe
    write_rate(0);
    fs_ctrl = 8'h00; pulse_fs();
    chk("R10 hold mode", mag_a, 12);
    chk("R11 fault one", fault_cnt, exp_fault);
    fs_ctrl = 8'h01; pulse_fs();
    chk("R10 zero mode mag", mag_a, 0);
    chk("R10 zero mode dir", dir_a, 0);
    chk("R11 fault two", fault_cnt, exp_fault);
    drv_a = 8'hA0; pulse_force();
    chk("R10 recover", mag_a, 32);
    force_upd = 1'b1; fs_evt = 1'b1; step();
    force_upd = 1'b0; fs_evt = 1'b0; exp_fault++;
    chk("R10 clear beats update", mag_a, 0);
    chk("R10 clear beats update b", mag_b, 0);
    for (int i = 0; i < 260; i++) pulse_fs();
    chk("R11 saturated", fault_cnt, 255);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule